// File: doc/BRIEF.md
# SPI Interrupt Enable and Event Logic

This block sits beside an SPI core and decides when that core may interrupt the processor. It keeps a six-bit interrupt enable register that software reaches over a simple register bus. It derives six source conditions from the core's status lines, latches the event-type sources as sticky flags, and drives one registered interrupt line. That line is high when any source condition is true and its enable bit is set.

Two of the sources are levels taken straight from the core: received data waiting, and the transmit holding register able to take a word. Four are events that stay latched until software clears them. These are a receive overrun and a transmit underrun, both seen only while the core runs as a slave, and two events on the slave-select lines. The first fires when any select line becomes asserted. The second fires when every line is released again. The enable register has separate set and clear addresses, so a driver can change one bit without a read-modify-write.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the enable register, all four sticky flags and `irq` are 0.
- R2: A write to address 0 sets every enable bit whose write-data bit is 1 and leaves the others unchanged. A read of address 0 or 1 returns the enable value in bits 5:0 and 0 above. Source positions in every six-bit field are: 0 receive ready, 1 transmit ready, 2 overrun, 3 underrun, 4 select asserted, 5 select released.
- R3: A write to address 1 clears every enable bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A read of address 2 returns, at the positions of R2, the status: `rx_valid`, `tx_empty` and the four sticky flags. The same vector is always on `status`. A write to address 2 clears each sticky flag whose write-data bit (2 to 5) is 1. An event in the same cycle wins over the clear.
- R5: Bits 0 and 1 of the status follow `rx_valid` and `tx_empty` as levels, with no latching.
- R6: With `slave_mode` high, a cycle with `rx_store_req` and `rx_valid` both high sets the overrun flag (bit 2) at that clock edge.
- R7: With `slave_mode` low, `rx_store_req` never sets the overrun flag, whatever the value of `rx_valid`.
- R8: With `slave_mode` high, a cycle with `tx_load_req` high and `tx_empty` low sets the underrun flag (bit 3).
- R9: The select lines are active low. When any line goes from 1 to 0 between two clock edges, flag bit 4 is set.
- R10: When all lines are 1 and at least one line was 0 at the previous edge, flag bit 5 is set.
- R11: `irq` is a register. After each edge it equals the OR, over the six sources, of the source condition ANDed with its enable bit, as both stood before that edge.
- R12: A write to any other address changes nothing. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| rx_valid | input | 1 | Receive data register holds an unread word |
| tx_empty | input | 1 | Transmit holding register can take a word |
| slave_mode | input | 1 | Core runs as slave when high |
| rx_store_req | input | 1 | Slave core must store a newly received word |
| tx_load_req | input | 1 | Slave core needs a word to shift out |
| ssel_n | input | NSEL | Slave-select lines, active low |
| status | output | 6 | Levels and sticky flags, positions as in R2 |
| irq | output | 1 | Combined registered interrupt |

## Verification
Register reads and `status` are combinational, so they are due right after the edge that updates the state behind them. A sticky flag is due after the edge that samples its event. `irq` follows one edge after the condition and enable it depends on, which for an event means two edges after the event. The bench drives every input on the falling edge and steps a reference model once per rising edge. It compares all outputs on the next falling edge, so each result is checked at the edge where it is due.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int NSRC = 6;
   localparam int NSTK = 4;
   // source positions in every six-bit field
   localparam int SRC_RXRDY = 0;
   localparam int SRC_TXRDY = 1;
   localparam int SRC_OVR   = 2;
   localparam int SRC_UDR   = 3;
   localparam int SRC_SELA  = 4;
   localparam int SRC_SELD  = 5;
   // sticky flag indices inside the event block
   localparam int STK_OVR  = 0;
   localparam int STK_UDR  = 1;
   localparam int STK_SELA = 2;
   localparam int STK_SELD = 3;
   typedef logic [NSRC-1:0] src_vec_t;
   typedef logic [NSTK-1:0] stk_vec_t;
endpackage

// File: rtl/spi_irq_enable_reg.sv
module spi_irq_enable_reg
   import spi_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     set_stb,
   input  logic     clr_stb,
   input  src_vec_t wbits,
   output src_vec_t en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (set_stb) en_q <= en_q | wbits;
      else if (clr_stb) en_q <= en_q & ~wbits;
   end

   // R2: a set write never drops a bit
   a_r2_set_only: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((en_q & $past(en_q)) == $past(en_q)));
   // R3: a clear write never raises a bit
   a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> ((en_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/spi_irq_events.sv
module spi_irq_events
   import spi_irq_pkg::*;
#(
   parameter int NSEL        = 4,
   parameter bit SEL_ACT_LOW = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slave_mode,
   input  logic            rx_valid,
   input  logic            tx_empty,
   input  logic            rx_store_req,
   input  logic            tx_load_req,
   input  logic [NSEL-1:0] sel_lines,
   input  logic            clr_stb,
   input  stk_vec_t        clr_bits,
   output stk_vec_t        sticky_q
);
   logic [NSEL-1:0] asrt_cur, asrt_prev;
   stk_vec_t        ev;

   generate
      if (SEL_ACT_LOW) begin : g_low
         assign asrt_cur = ~sel_lines;
      end else begin : g_high
         assign asrt_cur = sel_lines;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) asrt_prev <= '0;
      else        asrt_prev <= asrt_cur;
   end

   always_comb begin
      ev           = '0;
      ev[STK_OVR]  = slave_mode & rx_store_req & rx_valid;
      ev[STK_UDR]  = slave_mode & tx_load_req & ~tx_empty;
      ev[STK_SELA] = |(asrt_cur & ~asrt_prev);
      ev[STK_SELD] = (asrt_cur == '0) && (asrt_prev != '0);
   end

   generate
      for (genvar i = 0; i < NSTK; i++) begin : g_stk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sticky_q[i] <= 1'b0;
            else        sticky_q[i] <= ev[i] | (sticky_q[i] & ~(clr_stb & clr_bits[i]));
         end
      end
   endgenerate

   // R6: the overrun flag holds until cleared
   a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[STK_OVR] && !(clr_stb && clr_bits[STK_OVR])) |=> sticky_q[STK_OVR]);
   // R7: master mode cannot raise an overrun
   a_r7_master_no_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && !sticky_q[STK_OVR]) |=> !sticky_q[STK_OVR]);
   // R9: select-asserted flag only rises while some line is asserted
   a_r9_sela_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sticky_q[STK_SELA]) |-> $past(asrt_cur != '0));
   // R10: select-released flag only rises once all lines are released
   a_r10_seld_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sticky_q[STK_SELD]) |-> $past(asrt_cur == '0));
endmodule

// File: rtl/spi_irq_combine.sv
module spi_irq_combine
   import spi_irq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t cond,
   input  src_vec_t en,
   output logic     irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(cond & en);
   end

   // R11: with every enable off, the line stays low
   a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) == '0) |-> !irq_q);
   // R11: with no source true, the line stays low
   a_r11_no_cond_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cond) == '0) |-> !irq_q);
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int NSEL        = 4,
   parameter int ADR_SET     = 0,
   parameter int ADR_CLR     = 1,
   parameter int ADR_STAT    = 2,
   parameter bit SEL_ACT_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic              tx_empty,
   input  logic              slave_mode,
   input  logic              rx_store_req,
   input  logic              tx_load_req,
   input  logic [NSEL-1:0]   ssel_n,
   output logic [5:0]        status,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_SET  = ADR_SET[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_CLR  = ADR_CLR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_STAT = ADR_STAT[ADDR_W-1:0];

   generate
      if (DATA_W <= NSRC) begin : g_bad_width
         $error("DATA_W must exceed the source count");
      end
      if (NSEL < 1) begin : g_bad_nsel
         $error("NSEL must be at least 1");
      end
      if (ADR_SET == ADR_CLR || ADR_SET == ADR_STAT || ADR_CLR == ADR_STAT) begin : g_bad_map
         $error("register addresses must differ");
      end
      if (ADR_SET >= (1 << ADDR_W) || ADR_CLR >= (1 << ADDR_W) || ADR_STAT >= (1 << ADDR_W)) begin : g_bad_addr
         $error("register address does not fit ADDR_W");
      end
   endgenerate

   logic     set_stb, clr_stb, stat_stb;
   src_vec_t en_q, cond;
   stk_vec_t sticky_q;
   logic     unused_wdata;

   assign set_stb      = bus_wr && (bus_addr == A_SET);
   assign clr_stb      = bus_wr && (bus_addr == A_CLR);
   assign stat_stb     = bus_wr && (bus_addr == A_STAT);
   assign unused_wdata = ^bus_wdata[DATA_W-1:NSRC];

   spi_irq_enable_reg u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb),
      .clr_stb (clr_stb),
      .wbits   (bus_wdata[NSRC-1:0]),
      .en_q    (en_q)
   );

   spi_irq_events #(.NSEL(NSEL), .SEL_ACT_LOW(SEL_ACT_LOW)) u_ev (
      .clk          (clk),
      .rst_n        (rst_n),
      .slave_mode   (slave_mode),
      .rx_valid     (rx_valid),
      .tx_empty     (tx_empty),
      .rx_store_req (rx_store_req),
      .tx_load_req  (tx_load_req),
      .sel_lines    (ssel_n),
      .clr_stb      (stat_stb),
      .clr_bits     (bus_wdata[SRC_SELD:SRC_OVR]),
      .sticky_q     (sticky_q)
   );

   always_comb begin
      cond            = '0;
      cond[SRC_RXRDY] = rx_valid;
      cond[SRC_TXRDY] = tx_empty;
      cond[SRC_OVR]   = sticky_q[STK_OVR];
      cond[SRC_UDR]   = sticky_q[STK_UDR];
      cond[SRC_SELA]  = sticky_q[STK_SELA];
      cond[SRC_SELD]  = sticky_q[STK_SELD];
   end

   spi_irq_combine u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (cond),
      .en    (en_q),
      .irq_q (irq)
   );

   assign status = cond;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_SET || bus_addr == A_CLR) bus_rdata[NSRC-1:0] = en_q;
      else if (bus_addr == A_STAT)                bus_rdata[NSRC-1:0] = cond;
   end

   // R4: a flag with no event and a clear write for its bit drops
   a_r4_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_stb && bus_wdata[SRC_UDR] && !(slave_mode && tx_load_req && !tx_empty))
      |=> !status[SRC_UDR]);
   // R12: writes elsewhere leave the enables alone
   a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !set_stb && !clr_stb) |=> $stable(en_q));
endmodule

// File: tb/sim_spi_irq_ctrl.sv
module sim_spi_irq_ctrl;
   localparam int TCLK = 10;
   localparam int DW = 32;
   localparam int AW = 4;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          rx_valid = 1'b0, tx_empty = 1'b0, slave_mode = 1'b0;
   logic          rx_store_req = 1'b0, tx_load_req = 1'b0;
   logic [NS-1:0] ssel_n = '1;
   logic [5:0]    status;
   logic          irq;

   int errors = 0;
   int checks = 0;

   // reference model state
   logic [5:0]    m_en = '0;
   logic [3:0]    m_stk = '0;   // ovr, udr, sela, seld
   logic [NS-1:0] m_prev = '1;
   logic          m_irq = 1'b0;

   always #(TCLK/2) clk = ~clk;

   spi_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
      .tx_empty(tx_empty), .slave_mode(slave_mode), .rx_store_req(rx_store_req),
      .tx_load_req(tx_load_req), .ssel_n(ssel_n), .status(status), .irq(irq)
   );

   function automatic logic [5:0] exp_status();
      return {m_stk[3], m_stk[2], m_stk[1], m_stk[0], tx_empty, rx_valid};
   endfunction

   function automatic logic [DW-1:0] exp_read();
      logic [DW-1:0] r = '0;
      if (bus_addr == 0 || bus_addr == 1) r[5:0] = m_en;
      else if (bus_addr == 2)             r[5:0] = exp_status();
      return r;
   endfunction

   task automatic check(input string tag, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check(tag, "irq", DW'(irq), DW'(m_irq));
      check(tag, "status", DW'(status), DW'(exp_status()));
      check(tag, "rdata", bus_rdata, exp_read());
   endtask

   // advance one edge with the inputs now applied, then compare
   task automatic step(input string tag);
      logic [5:0]    en_n;
      logic [3:0]    stk_n, ev, clr;
      logic [NS-1:0] ac, ap;
      logic          irq_n;
      ac = ~ssel_n;
      ap = ~m_prev;
      ev[0] = slave_mode && rx_store_req && rx_valid;
      ev[1] = slave_mode && tx_load_req && !tx_empty;
      ev[2] = |(ac & ~ap);
      ev[3] = (ac == '0) && (ap != '0);
      clr   = (bus_wr && bus_addr == 2) ? bus_wdata[5:2] : 4'b0;
      stk_n = ev | (m_stk & ~clr);
      en_n  = m_en;
      if (bus_wr && bus_addr == 0)      en_n = m_en | bus_wdata[5:0];
      else if (bus_wr && bus_addr == 1) en_n = m_en & ~bus_wdata[5:0];
      irq_n = |(exp_status() & m_en);
      @(posedge clk);
      @(negedge clk);
      m_en = en_n; m_stk = stk_n; m_prev = ssel_n; m_irq = irq_n;
      check_all(tag);
      bus_wr = 1'b0;
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      bus_addr = AW'(a); bus_wr = 1'b1; bus_wdata = d;
   endtask

   task automatic rd(input int a);
      bus_addr = AW'(a); bus_wr = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");
      rd(0); step("R1 idle");

      // R2 set-only writes
      wr(0, 32'h0000_0005); step("R2 set");
      wr(0, 32'h0000_0000); step("R2 zero write");
      rd(0); step("R2 readback");
      // R3 clear writes
      wr(1, 32'h0000_0001); step("R3 clear");
      rd(1); step("R3 readback");
      // R5 and R11 levels
      wr(0, 32'h0000_003F); step("R2 set all");
      rx_valid = 1'b1; rd(2); step("R5 rx level");
      step("R11 irq from rx");
      rx_valid = 1'b0; tx_empty = 1'b1; step("R5 tx level");
      tx_empty = 1'b0; step("R11 irq follows");
      step("R11 irq low");
      // R6 overrun in slave mode
      slave_mode = 1'b1; rx_valid = 1'b1; rx_store_req = 1'b1; step("R6 overrun");
      rx_store_req = 1'b0; rx_valid = 1'b0; step("R6 held");
      wr(2, 32'h0000_0004); step("R4 clear ovr");
      // R7 master mode
      slave_mode = 1'b0; rx_valid = 1'b1; rx_store_req = 1'b1; step("R7 master");
      rx_store_req = 1'b0; rx_valid = 1'b0; step("R7 master after");
      // R8 underrun
      slave_mode = 1'b1; tx_load_req = 1'b1; tx_empty = 1'b0; step("R8 underrun");
      tx_load_req = 1'b0; step("R8 held");
      // R4 event beats clear in the same cycle
      tx_load_req = 1'b1; wr(2, 32'h0000_0008); step("R4 set wins");
      tx_load_req = 1'b0; wr(2, 32'h0000_0008); step("R4 clear udr");
      // R9 and R10 select edges
      ssel_n = 4'b1110; rd(2); step("R9 assert");
      ssel_n = 4'b1010; step("R9 second line");
      ssel_n = 4'b1011; step("R10 partial release");
      ssel_n = 4'b1111; step("R10 all released");
      step("R10 held");
      // R12 unmapped address
      wr(3, 32'hFFFF_FFFF); step("R12 write");
      rd(3); step("R12 read");
      wr(1, 32'h0000_003F); step("R3 clear all");
      wr(2, 32'h0000_003C); step("R4 clear all");
      rd(0); step("R12 enables kept");

      // random mix
      for (int i = 0; i < 400; i++) begin
         bus_addr     = AW'($urandom_range(0, 3));
         bus_wr       = ($urandom_range(0, 9) < 3);
         bus_wdata    = $urandom;
         rx_valid     = $urandom_range(0, 1) == 1;
         tx_empty     = $urandom_range(0, 1) == 1;
         slave_mode   = $urandom_range(0, 1) == 1;
         rx_store_req = $urandom_range(0, 3) == 0;
         tx_load_req  = $urandom_range(0, 3) == 0;
         if ($urandom_range(0, 3) == 0) ssel_n = NS'($urandom);
         step("R11 random");
      end
      finish_run();
   end
endmodule